// File: doc/BRIEF.md
# Thermostat Alert with Fault Queue

This block turns a stream of temperature conversion results into a thermostat alert. Every strobe carries a new signed 12-bit reading. The block compares that reading against a high limit and a low limit. A programmable consecutive-fault filter stops single noisy readings from changing the alert. The alert pin level is produced for either active-low or active-high wiring. A status bit reports whether the alert that is active came from the high limit or from the low limit.

Two operating modes are supported. In comparator mode the alert is a hysteresis thermostat: it turns on above the high limit and off below the low limit. In interrupt mode the alert is an event latch that waits for software. It alternates between arming on the high limit and arming on the low limit. A pending event is released by a register read, by a won alert-response arbitration, or by entry into shutdown. A general call reset returns the block to its idle high-armed state from any state.

The sequencer has four states. ARM_HIGH: alert off, counting readings at or above the high limit. HELD_HIGH: alert on from a high event. ARM_LOW: interrupt mode only, alert off, counting readings below the low limit. HELD_LOW: interrupt mode only, alert on from a low event.

Transitions:
- ARM_HIGH goes to HELD_HIGH when the queue fills.
- HELD_HIGH goes to ARM_HIGH when the queue fills with low readings (comparator mode).
- HELD_HIGH goes to ARM_LOW on a clear (interrupt mode).
- ARM_LOW goes to HELD_LOW when the queue fills.
- HELD_LOW goes to ARM_HIGH on a clear.
- ARM_LOW goes to ARM_HIGH, and HELD_LOW goes to HELD_HIGH, when the mode bit reads comparator.
- Any state goes to ARM_HIGH on a general call reset.

Top module: `therm_alert`

## Requirements
- R1: After the asynchronous reset the alert is inactive, the status bit is 0 and the fault count is 0.
- R2: The fault code selects how many consecutive qualifying conversions are needed: code 0 needs 1, code 1 needs 2, code 2 needs 4 and code 3 needs 6. The alert changes at the clock edge that samples the strobe of the last required conversion.
- R3: A strobed reading that does not meet the armed condition, including the opposite-limit condition, resets the fault count to 0. Cycles without a strobe leave the count unchanged.
- R4: The comparisons are signed two's complement over all 12 bits. A reading counts as high when it is at or above the high limit, and as low when it is strictly below the low limit. A reading equal to the low limit is not low.
- R5: In comparator mode (mode bit 0) the alert asserts after the required count of high readings. It deasserts after the same count of low readings. Read, alert-response and shutdown clears have no effect in this mode.
- R6: In interrupt mode (mode bit 1) the alert asserts after the required count of high readings. It then ignores conversions and stays active until a read, a won alert response or a shutdown entry clears it at the next edge.
- R7: After a high event is cleared in interrupt mode, only the required count of low readings raises the alert again. Clearing that low event re-arms the high limit.
- R8: A clear event that arrives while the alert is inactive has no effect on arming or on the fault count.
- R9: With polarity bit 0 the pin is low when the alert is active. With polarity bit 1 the pin is high when the alert is active. The pin follows the polarity bit with no clock edge.
- R10: A general call reset clears the alert and the fault count and re-arms the high limit. It takes priority over a strobe or a clear in the same cycle.
- R11: The status bit is 1 while the alert is active from a high event, and 0 when the event is a low event or when no alert is active.
- R12: When the mode bit reads comparator, ARM_LOW moves to ARM_HIGH and HELD_LOW moves to HELD_HIGH at the next edge. The alert level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_valid | input | 1 | One-cycle strobe marking a new conversion result |
| conv_temp | input | 12 | Signed conversion result |
| lim_high | input | 12 | Signed high limit |
| lim_low | input | 12 | Signed low limit |
| fault_sel | input | 2 | Consecutive-fault code (1, 2, 4, 6) |
| mode_int | input | 1 | 0 comparator mode, 1 interrupt mode |
| pol_high | input | 1 | 0 active-low pin, 1 active-high pin |
| clr_read | input | 1 | Pulse: some register was read |
| clr_resp_win | input | 1 | Pulse: alert response arbitration won |
| clr_shutdown | input | 1 | Pulse: shutdown entered |
| gc_reset | input | 1 | Pulse: general call reset |
| alert_pin | output | 1 | Alert pin level after polarity |
| alert_high | output | 1 | Status: 1 for a high-limit event |

## Verification
A strobe, a clear or a general call reset is registered at one rising edge. Both alert_pin and alert_high show the result from that edge on. The polarity bit acts on alert_pin within the same cycle. The bench changes inputs on falling edges and reads outputs on the next falling edge, which is half a period after the edge that registers the stimulus. It reads the pin a short delay after a polarity change with no edge in between. Expected levels come from a behavioural model in the bench that is stepped once per driven cycle.

// File: rtl/therm_alert_pkg.sv
package therm_alert_pkg;

    localparam int CNT_W = 3;

    typedef enum logic [1:0] {
        ARM_HIGH  = 2'd0,
        HELD_HIGH = 2'd1,
        ARM_LOW   = 2'd2,
        HELD_LOW  = 2'd3
    } arm_state_e;

    // consecutive conversions required per fault code (R2)
    function automatic logic [CNT_W-1:0] fault_need(input logic [1:0] code);
        logic [CNT_W-1:0] n;
        unique case (code)
            2'd0:    n = CNT_W'(1);
            2'd1:    n = CNT_W'(2);
            2'd2:    n = CNT_W'(4);
            default: n = CNT_W'(6);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/therm_compare.sv
module therm_compare #(
    parameter int TEMP_W = 12
) (
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] lim_hi,
    input  logic [TEMP_W-1:0] lim_lo,
    input  logic              watch_high,
    output logic              at_high,
    output logic              below_low,
    output logic              match
);
    // full-width signed comparison (R4)
    always_comb begin
        at_high   = ($signed(temp) >= $signed(lim_hi));
        below_low = ($signed(temp) <  $signed(lim_lo));
        match     = watch_high ? at_high : below_low;
    end
endmodule

// File: rtl/therm_fault_queue.sv
module therm_fault_queue
    import therm_alert_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       match,
    input  logic       restart,
    input  logic [1:0] code,
    output logic       fire
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [SUM_W-1:0] cnt_inc;
    logic [CNT_W-1:0] need;

    always_comb begin
        need    = fault_need(code);
        cnt_inc = {1'b0, cnt} + SUM_W'(1);
        fire    = en && match && (cnt_inc >= {1'b0, need});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (en) begin
            if (match && !fire) cnt <= cnt_inc[CNT_W-1:0];
            else                cnt <= '0;
        end
    end

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(6));

    assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !restart) |=> $stable(cnt));

    assert_cnt_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !match) |=> (cnt == '0));

endmodule

// File: rtl/therm_alert_fsm.sv
module therm_alert_fsm
    import therm_alert_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_int,
    input  logic fire,
    input  logic clr_any,
    input  logic gc_reset,
    output logic watch_high,
    output logic count_en,
    output logic restart,
    output logic active,
    output logic status_high
);
    arm_state_e st, st_nxt;

    always_comb begin
        st_nxt = st;
        if (gc_reset) begin
            st_nxt = ARM_HIGH;
        end else begin
            unique case (st)
                ARM_HIGH: begin
                    if (fire) st_nxt = HELD_HIGH;
                end
                HELD_HIGH: begin
                    if (mode_int) begin
                        if (clr_any) st_nxt = ARM_LOW;
                    end else if (fire) begin
                        st_nxt = ARM_HIGH;
                    end
                end
                ARM_LOW: begin
                    if (!mode_int)  st_nxt = ARM_HIGH;
                    else if (fire)  st_nxt = HELD_LOW;
                end
                HELD_LOW: begin
                    if (!mode_int)     st_nxt = HELD_HIGH;
                    else if (clr_any)  st_nxt = ARM_HIGH;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ARM_HIGH;
        else        st <= st_nxt;
    end

    always_comb begin
        watch_high  = 1'b0;
        count_en    = 1'b0;
        active      = 1'b0;
        status_high = 1'b0;
        unique case (st)
            ARM_HIGH: begin
                watch_high = 1'b1;
                count_en   = 1'b1;
            end
            HELD_HIGH: begin
                count_en    = !mode_int;
                active      = 1'b1;
                status_high = 1'b1;
            end
            ARM_LOW: begin
                count_en = mode_int;
            end
            HELD_LOW: begin
                active = 1'b1;
            end
        endcase
        restart = gc_reset || (st_nxt != st);
    end

    assert_rise_on_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(fire));

    assert_gc_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        gc_reset |=> (!active && watch_high));

    assert_int_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_int && clr_any && active && !gc_reset) |=> !active);

    assert_cmp_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_int && !gc_reset && !fire) |=> $stable(active));

endmodule

// File: rtl/therm_alert.sv
module therm_alert #(
    parameter int TEMP_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [TEMP_W-1:0] conv_temp,
    input  logic [TEMP_W-1:0] lim_high,
    input  logic [TEMP_W-1:0] lim_low,
    input  logic [1:0]        fault_sel,
    input  logic              mode_int,
    input  logic              pol_high,
    input  logic              clr_read,
    input  logic              clr_resp_win,
    input  logic              clr_shutdown,
    input  logic              gc_reset,
    output logic              alert_pin,
    output logic              alert_high
);
    logic watch_high, count_en, restart, active, status_high;
    logic at_high, below_low, match, fire, clr_any;

    assign clr_any = clr_read || clr_resp_win || clr_shutdown;

    therm_compare #(.TEMP_W(TEMP_W)) u_cmp (
        .temp       (conv_temp),
        .lim_hi     (lim_high),
        .lim_lo     (lim_low),
        .watch_high (watch_high),
        .at_high    (at_high),
        .below_low  (below_low),
        .match      (match)
    );

    therm_fault_queue u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (conv_valid && count_en),
        .match   (match),
        .restart (restart),
        .code    (fault_sel),
        .fire    (fire)
    );

    therm_alert_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_int    (mode_int),
        .fire        (fire),
        .clr_any     (clr_any),
        .gc_reset    (gc_reset),
        .watch_high  (watch_high),
        .count_en    (count_en),
        .restart     (restart),
        .active      (active),
        .status_high (status_high)
    );

    // polarity applied last (R9)
    always_comb begin
        alert_pin  = pol_high ? active : !active;
        alert_high = status_high;
    end

    assert_cmp_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(at_high && below_low && ($signed(lim_high) >= $signed(lim_low))));

endmodule

// File: tb/therm_alert_test.sv
module therm_alert_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_valid = 1'b0;
    logic [11:0] conv_temp = '0;
    logic [11:0] lim_high = 12'h500;
    logic [11:0] lim_low = 12'h4B0;
    logic [1:0]  fault_sel = 2'd0;
    logic        mode_int = 1'b0;
    logic        pol_high = 1'b0;
    logic        clr_read = 1'b0, clr_resp_win = 1'b0, clr_shutdown = 1'b0;
    logic        gc_reset = 1'b0;
    logic        alert_pin, alert_high;

    int n_cmp = 0, n_bad = 0;
    int m_st = 0, m_cnt = 0;
    bit done = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    therm_alert uut (.*);

    function automatic int sx(input logic [11:0] v);
        return v[11] ? int'(v) - 4096 : int'(v);
    endfunction

    task automatic check(input string tag);
        bit act = (m_st == 1) || (m_st == 3);
        logic ep = pol_high ? act : !act;
        logic es = (m_st == 1);
        n_cmp++;
        if (alert_pin !== ep) begin
            n_bad++;
            $display("FAIL %s alert_pin actual=%b expected=%b", tag, alert_pin, ep);
        end
        n_cmp++;
        if (alert_high !== es) begin
            n_bad++;
            $display("FAIL %s alert_high actual=%b expected=%b", tag, alert_high, es);
        end
    endtask

    // behavioural model, one call per driven cycle
    task automatic model(input bit v, input logic [11:0] t, input bit clr, input bit g);
        int need = (fault_sel == 0) ? 1 : (fault_sel == 1) ? 2 : (fault_sel == 2) ? 4 : 6;
        bit hit;
        if (g) begin
            m_st = 0; m_cnt = 0;
        end else if (!mode_int && m_st == 2) begin
            m_st = 0; m_cnt = 0;
        end else if (!mode_int && m_st == 3) begin
            m_st = 1; m_cnt = 0;
        end else if (mode_int && (m_st == 1 || m_st == 3) && clr) begin
            m_st = (m_st == 1) ? 2 : 0; m_cnt = 0;
        end else if (v && (m_st == 0 || (m_st == 1 && !mode_int) || (m_st == 2 && mode_int))) begin
            hit = (m_st == 0) ? (sx(t) >= sx(lim_high)) : (sx(t) < sx(lim_low));
            if (hit) begin
                m_cnt++;
                if (m_cnt >= need) begin
                    m_st = (m_st == 0) ? 1 : (m_st == 1) ? 0 : 3;
                    m_cnt = 0;
                end
            end else begin
                m_cnt = 0;
            end
        end
    endtask

    task automatic step(input bit v, input logic [11:0] t, input bit rd, input bit rs,
                        input bit sd, input bit g, input string tag);
        @(negedge clk);
        conv_valid = v; conv_temp = t; clr_read = rd; clr_resp_win = rs;
        clr_shutdown = sd; gc_reset = g;
        model(v, t, rd | rs | sd, g);
        @(negedge clk);
        conv_valid = 0; clr_read = 0; clr_resp_win = 0; clr_shutdown = 0; gc_reset = 0;
        check(tag);
    endtask

    task automatic temp_in(input logic [11:0] t, input string tag);
        step(1, t, 0, 0, 0, 0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [11:0] vals [9];
        vals = '{12'h500, 12'h501, 12'h7FF, 12'h4AF, 12'hE70, 12'h800, 12'h4FF, 12'h4B0, 12'h4C0};
        repeat (3) @(negedge clk);
        check("R1 reset state");
        rst_n = 1;
        @(negedge clk);
        check("R1 after release");

        // R4: equality at high triggers, equality at low does not count, signed min is low
        temp_in(12'h500, "R4 equal high");
        temp_in(12'h4B0, "R4 equal low not below");
        temp_in(12'h4AF, "R4 one below low");
        temp_in(12'h800, "R4 signed minimum not high");
        lim_high = 12'h501;
        temp_in(12'h500, "R4 lowest bit compared");
        lim_high = 12'h500;

        // R9: polarity without a clock edge
        temp_in(12'h7FF, "R9 alert on");
        pol_high = 1; #1; check("R9 active high pin");
        pol_high = 0; #1; check("R9 active low pin");

        // R10: general call beats a strobe
        step(1, 12'h4AF, 0, 0, 0, 1, "R10 gc priority");

        // R3: count survives idle cycles, broken by mid reading
        fault_sel = 2;
        temp_in(12'h500, "R3 count 1"); temp_in(12'h500, "R3 count 2");
        step(0, 0, 0, 0, 0, 0, "R3 idle"); step(0, 0, 1, 0, 0, 0, "R8 clear while idle");
        temp_in(12'h500, "R3 count 3"); temp_in(12'h501, "R2 fourth fires");
        temp_in(12'h4AF, "R5 low 1"); temp_in(12'h4C0, "R3 mid breaks");
        step(0, 0, 1, 1, 1, 0, "R5 clears ignored");
        repeat (3) temp_in(12'hE70, "R5 low run");
        temp_in(12'h800, "R5 deassert");

        // R6 R7 R8 R11 R12 in interrupt mode
        step(1, 0, 0, 0, 0, 1, "R10 gc");
        mode_int = 1; fault_sel = 1;
        temp_in(12'h600, "R8 high 1");
        step(0, 0, 1, 0, 0, 0, "R8 read while armed");
        temp_in(12'h600, "R6 high event");
        temp_in(12'h800, "R6 strobes ignored");
        step(0, 0, 0, 1, 0, 0, "R6 response clear");
        temp_in(12'h600, "R7 high ignored"); temp_in(12'h4AF, "R7 low 1");
        temp_in(12'h4AF, "R11 low event");
        mode_int = 0;
        step(0, 0, 0, 0, 0, 0, "R12 low to high held");
        mode_int = 1;
        step(0, 0, 0, 0, 1, 0, "R6 shutdown clear");

        // sweep of fault code, mode and polarity
        for (int cfg = 0; cfg < 16; cfg++) begin
            int cls = 0;
            fault_sel = cfg[1:0]; mode_int = cfg[2]; pol_high = cfg[3];
            step(0, 0, 0, 0, 0, 1, "R10 sweep gc");
            for (int s = 0; s < 120; s++) begin
                seed = seed * 32'd1664525 + 32'd1013904223;
                if (seed[31:29] == 0) begin
                    step(0, 0, seed[27:26] == 0, seed[27:26] == 1, seed[27:26] == 2, 0,
                         "R6/R8 sweep clear");
                end else begin
                    if (seed[28:27] == 0) cls = int'(seed[20:16]) % 3;
                    temp_in(vals[cls * 3 + int'(seed[12:8]) % 3], "R2/R3/R5/R7 sweep");
                end
            end
        end
        finish_run();
    end
endmodule